// File: doc/BRIEF.md
# Full-Speed Serial Bus Packet Receiver

This block sits behind a line sampler that has already recovered the bit clock. On every cycle where the bit strobe is high it takes one line state, given as a differential data level plus a single-ended-zero flag. It waits on the idle bus until it sees a complete synchronisation pattern. It then turns the NRZI line levels back into data bits and drops the bits that were stuffed into the stream. It packs the data bits into bytes, least significant bit first, and delivers them on a byte-wide output with a valid strobe.

The first byte after the synchronisation pattern is the packet identifier. It is checked for a correct complement nibble and for membership in the set of known identifiers, and its low nibble is presented as a 4-bit type code. Every bit after the identifier runs through a 5-bit and a 16-bit CRC register in parallel. When the end-of-packet signalling arrives, the block raises a one-cycle end strobe. Three status levels go with it: identifier accepted, CRC and length accepted, and framing error.

Top module: `usb_fs_rx`

## Requirements
- R1: The line state is J when rx_se0=0 and rx_dp=1, K when rx_se0=0 and rx_dp=0, and single-ended zero whenever rx_se0=1. A packet begins only after the eight states K J K J K J K K. Any broken or incomplete pattern produces no start, no byte and no end strobe.
- R2: NRZI decoding works from the last K of the synchronisation pattern as the reference level. A level change between consecutive bits decodes as 0 and an unchanged level decodes as 1.
- R3: The ones counter is cleared at the end of the synchronisation pattern. After six decoded ones in a row, the next line bit is a stuffed bit: it is discarded, it is not delivered, and the counter is cleared.
- R4: If a stuffed bit position shows no level change, the packet ends with rx_frame_err=1.
- R5: Bits are packed into bytes least significant bit first. The identifier byte appears on rx_byte with rx_byte_vld and rx_pkt_start high in the same cycle. Each later complete byte appears with rx_byte_vld alone.
- R6: rx_pid is the low nibble of the identifier byte. rx_pid_ok=1 requires the high nibble to equal the bitwise complement of the low nibble and the byte to be one of 0xE1, 0x69, 0xA5, 0x2D, 0xC3, 0x4B, 0xD2, 0x5A, 0x1E or 0x3C.
- R7: For a token type (low two identifier bits 01), rx_crc_ok=1 requires exactly two bytes after the identifier and the 5-bit register holding 0b01100. The register is seeded with all ones after the identifier, and each bit is processed as: XOR the MSB with the bit, shift left, and XOR in 0b00101 if the XOR result was 1.
- R8: For a data type (low two bits 11), rx_crc_ok=1 requires at least two bytes after the identifier and the 16-bit register (same procedure, polynomial 0x8005) holding 0x800D.
- R9: For the other types (low two bits 10 or 00), rx_crc_ok=1 requires no bytes after the identifier. An identifier that fails R6 always gives rx_crc_ok=0.
- R10: The end of a packet is two single-ended-zero states followed by J. It gives a one-cycle rx_pkt_end, which never coincides with rx_byte_vld. Any other end shape, such as one single-ended zero followed by a data state, still ends the packet but sets rx_frame_err=1.
- R11: rx_frame_err=1 when the end arrives with 1 to 7 bits of a byte pending, or before a full identifier byte was received.
- R12: Cycles with bit_en=0 change no state, whatever rx_dp and rx_se0 carry.
- R13: After reset all strobes, rx_byte, rx_pid and the three status flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | One line state is present this cycle |
| rx_dp | input | 1 | Differential data level (1 = J) |
| rx_se0 | input | 1 | Single-ended-zero flag |
| rx_byte | output | 8 | Received byte |
| rx_byte_vld | output | 1 | rx_byte holds a new byte |
| rx_pkt_start | output | 1 | This byte is the identifier |
| rx_pkt_end | output | 1 | Packet ended; status flags valid |
| rx_pid | output | 4 | Low nibble of the identifier |
| rx_pid_ok | output | 1 | Identifier accepted |
| rx_crc_ok | output | 1 | CRC residual and length accepted |
| rx_frame_err | output | 1 | Stuffing, end-shape, partial-byte or short-packet error |

## Verification
Several situations are hard to reach from the ports. One is a stuffed bit that falls right before the end signalling. Another is a stuffed position that carries no transition, which is a stream no well-formed transmitter would produce. The bench therefore holds its own encoder. It takes a list of plain bits, computes and appends the inverted CRC itself, applies NRZI and stuffing, and on request skips the transition at the first stuffed position. Runs of 0xFF bytes and an all-ones frame field place stuffed bits everywhere, including next to the end of the packet.

// File: rtl/usb_rx_pkg.sv
package usb_rx_pkg;

  localparam int CRC5_W  = 5;
  localparam int CRC16_W = 16;
  localparam logic [CRC5_W-1:0]  CRC5_POLY   = 5'b00101;
  localparam logic [CRC5_W-1:0]  CRC5_RESID  = 5'b01100;
  localparam logic [CRC16_W-1:0] CRC16_POLY  = 16'h8005;
  localparam logic [CRC16_W-1:0] CRC16_RESID = 16'h800D;

  // class of a packet identifier, from its two lowest bits
  typedef enum logic [1:0] {
    PK_SPECIAL = 2'b00,
    PK_TOKEN   = 2'b01,
    PK_HAND    = 2'b10,
    PK_DATA    = 2'b11
  } pid_kind_e;

  typedef enum logic [1:0] {
    L_HUNT,
    L_DATA,
    L_EOP1,
    L_EOP2
  } line_state_e;

  function automatic logic pid_known(input logic [7:0] p);
    logic listed;
    listed = (p inside {8'hE1, 8'h69, 8'hA5, 8'h2D, 8'hC3,
                        8'h4B, 8'hD2, 8'h5A, 8'h1E, 8'h3C});
    return listed && (p[7:4] == ~p[3:0]);
  endfunction

endpackage

// File: rtl/usb_rx_line.sv
module usb_rx_line
  import usb_rx_pkg::*;
#(
  parameter int STUFF_LEN = 6,
  parameter int SYNC_LEN  = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic rx_dp,
  input  logic rx_se0,
  output logic bit_vld,
  output logic bit_val,
  output logic sop,
  output logic eop,
  output logic eop_bad,
  output logic stuff_err
);

  localparam int OW = $clog2(STUFF_LEN + 1);
  localparam int SW = $clog2(SYNC_LEN);

  line_state_e     state;
  logic [SW-1:0]   sync_pos;
  logic            prev_lvl;
  logic [OW-1:0]   ones;
  logic            sync_want;
  logic            nrzi_one;

  // pattern: alternating K,J,... and a closing K
  assign sync_want = (sync_pos == SW'(SYNC_LEN - 1)) ? 1'b0 : sync_pos[0];
  assign nrzi_one  = (rx_dp == prev_lvl);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= L_HUNT;
      sync_pos  <= '0;
      prev_lvl  <= 1'b0;
      ones      <= '0;
      bit_vld   <= 1'b0;
      bit_val   <= 1'b0;
      sop       <= 1'b0;
      eop       <= 1'b0;
      eop_bad   <= 1'b0;
      stuff_err <= 1'b0;
    end else begin
      bit_vld   <= 1'b0;
      sop       <= 1'b0;
      eop       <= 1'b0;
      eop_bad   <= 1'b0;
      stuff_err <= 1'b0;
      if (bit_en) begin
        unique case (state)
          L_HUNT: begin
            if (rx_se0) begin
              sync_pos <= '0;
            end else if (rx_dp == sync_want) begin
              if (sync_pos == SW'(SYNC_LEN - 1)) begin
                state    <= L_DATA;
                sop      <= 1'b1;
                prev_lvl <= 1'b0;
                ones     <= '0;
                sync_pos <= '0;
              end else begin
                sync_pos <= sync_pos + SW'(1);
              end
            end else begin
              sync_pos <= rx_dp ? '0 : SW'(1);
            end
          end
          L_DATA: begin
            if (rx_se0) begin
              state <= L_EOP1;
            end else begin
              prev_lvl <= rx_dp;
              if (ones == OW'(STUFF_LEN)) begin
                ones      <= '0;
                stuff_err <= nrzi_one;
              end else begin
                bit_vld <= 1'b1;
                bit_val <= nrzi_one;
                ones    <= nrzi_one ? ones + OW'(1) : '0;
              end
            end
          end
          L_EOP1: begin
            if (rx_se0) begin
              state <= L_EOP2;
            end else begin
              state   <= L_HUNT;
              eop     <= 1'b1;
              eop_bad <= 1'b1;
            end
          end
          L_EOP2: begin
            state   <= L_HUNT;
            eop     <= 1'b1;
            eop_bad <= rx_se0 | ~rx_dp;
          end
          default: state <= L_HUNT;
        endcase
      end
    end
  end

  // R3: a line bit at a stuffed position is never delivered
  a_r3_stuffed_dropped: assert property (@(posedge clk) disable iff (rst)
    (bit_en && state == L_DATA && !rx_se0 && ones == OW'(STUFF_LEN)) |=> !bit_vld);

  // R12: without a strobe nothing is produced
  a_r12_no_strobe_quiet: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> (!bit_vld && !sop && !eop && !stuff_err));

  // R1: a packet start always follows an accepted K state
  a_r1_start_after_k: assert property (@(posedge clk) disable iff (rst)
    sop |-> $past(bit_en && !rx_se0 && !rx_dp));

endmodule

// File: rtl/usb_rx_crc.sv
module usb_rx_crc #(
  parameter int          W    = 5,
  parameter logic [W-1:0] POLY = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         init,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] rem
);

  logic fb;
  assign fb = rem[W-1] ^ din;

  always_ff @(posedge clk) begin
    if (rst || init) begin
      rem <= '1;
    end else if (en) begin
      rem <= {rem[W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
  end

  // R8: seeding and feeding are never requested together
  a_r8_seed_or_feed: assert property (@(posedge clk) disable iff (rst)
    !(init && en));

  // R8: a seed request leaves all ones in the register
  a_r8_seed_all_ones: assert property (@(posedge clk) disable iff (rst)
    init |=> (rem == '1));

endmodule

// File: rtl/usb_rx_pack.sv
module usb_rx_pack
  import usb_rx_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bit_vld,
  input  logic               bit_val,
  input  logic               sop,
  input  logic               eop,
  input  logic               eop_bad,
  input  logic               stuff_err,
  input  logic [CRC5_W-1:0]  crc5_rem,
  input  logic [CRC16_W-1:0] crc16_rem,
  output logic               crc_init,
  output logic               crc_en,
  output logic               crc_bit,
  output logic [7:0]         byte_data,
  output logic               byte_vld,
  output logic               pkt_start,
  output logic               pkt_end,
  output logic [3:0]         pid_code,
  output logic               pid_ok,
  output logic               crc_ok,
  output logic               frame_err
);

  logic          in_pkt;
  logic [7:0]    shreg;
  logic [2:0]    bit_cnt;
  logic          pid_done;
  logic          pid_chk;
  logic          err_seen;
  logic [CW-1:0] nbytes;
  logic [7:0]    next_byte;
  logic          crc_pass;

  assign next_byte = {bit_val, shreg[7:1]};
  assign crc_init  = in_pkt && bit_vld && !pid_done && (bit_cnt == 3'd7);
  assign crc_en    = in_pkt && bit_vld && pid_done;
  assign crc_bit   = bit_val;

  always_comb begin
    unique case (pid_kind_e'(pid_code[1:0]))
      PK_TOKEN: crc_pass = (nbytes == CW'(2)) && (crc5_rem == CRC5_RESID);
      PK_DATA:  crc_pass = (nbytes >= CW'(2)) && (crc16_rem == CRC16_RESID);
      default:  crc_pass = (nbytes == '0);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_pkt    <= 1'b0;
      shreg     <= '0;
      bit_cnt   <= '0;
      pid_done  <= 1'b0;
      pid_chk   <= 1'b0;
      err_seen  <= 1'b0;
      nbytes    <= '0;
      byte_data <= '0;
      byte_vld  <= 1'b0;
      pkt_start <= 1'b0;
      pkt_end   <= 1'b0;
      pid_code  <= '0;
      pid_ok    <= 1'b0;
      crc_ok    <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      byte_vld  <= 1'b0;
      pkt_start <= 1'b0;
      pkt_end   <= 1'b0;
      if (sop) begin
        in_pkt   <= 1'b1;
        bit_cnt  <= '0;
        pid_done <= 1'b0;
        pid_chk  <= 1'b0;
        err_seen <= 1'b0;
        nbytes   <= '0;
      end else if (in_pkt) begin
        if (stuff_err) err_seen <= 1'b1;
        if (bit_vld) begin
          shreg   <= next_byte;
          bit_cnt <= bit_cnt + 3'd1;
          if (bit_cnt == 3'd7) begin
            byte_data <= next_byte;
            byte_vld  <= 1'b1;
            if (!pid_done) begin
              pkt_start <= 1'b1;
              pid_code  <= next_byte[3:0];
              pid_chk   <= pid_known(next_byte);
              pid_done  <= 1'b1;
            end else if (nbytes != '1) begin
              nbytes <= nbytes + CW'(1);
            end
          end
        end
        if (eop) begin
          in_pkt    <= 1'b0;
          pkt_end   <= 1'b1;
          pid_ok    <= pid_done && pid_chk;
          crc_ok    <= pid_done && pid_chk && crc_pass;
          frame_err <= eop_bad || err_seen || stuff_err ||
                       (bit_cnt != 3'd0) || !pid_done;
        end
      end
    end
  end

  // R5: the identifier is always delivered as a byte
  a_r5_start_with_byte: assert property (@(posedge clk) disable iff (rst)
    pkt_start |-> byte_vld);

  // R10: the end strobe never shares a cycle with a byte
  a_r10_end_apart: assert property (@(posedge clk) disable iff (rst)
    pkt_end |-> !byte_vld);

endmodule

// File: rtl/usb_fs_rx.sv
module usb_fs_rx
  import usb_rx_pkg::*;
#(
  parameter int STUFF_LEN = 6,
  parameter int SYNC_LEN  = 8,
  parameter int CW        = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bit_en,
  input  logic       rx_dp,
  input  logic       rx_se0,
  output logic [7:0] rx_byte,
  output logic       rx_byte_vld,
  output logic       rx_pkt_start,
  output logic       rx_pkt_end,
  output logic [3:0] rx_pid,
  output logic       rx_pid_ok,
  output logic       rx_crc_ok,
  output logic       rx_frame_err
);

  logic bit_vld, bit_val, sop, eop, eop_bad, stuff_err;
  logic crc_init, crc_en, crc_bit;
  logic [CRC5_W-1:0]  crc5_rem;
  logic [CRC16_W-1:0] crc16_rem;

  usb_rx_line #(.STUFF_LEN(STUFF_LEN), .SYNC_LEN(SYNC_LEN)) u_line (
    .clk(clk), .rst(rst), .bit_en(bit_en), .rx_dp(rx_dp), .rx_se0(rx_se0),
    .bit_vld(bit_vld), .bit_val(bit_val), .sop(sop), .eop(eop),
    .eop_bad(eop_bad), .stuff_err(stuff_err)
  );

  usb_rx_crc #(.W(CRC5_W), .POLY(CRC5_POLY)) u_crc5 (
    .clk(clk), .rst(rst), .init(crc_init), .en(crc_en), .din(crc_bit),
    .rem(crc5_rem)
  );

  usb_rx_crc #(.W(CRC16_W), .POLY(CRC16_POLY)) u_crc16 (
    .clk(clk), .rst(rst), .init(crc_init), .en(crc_en), .din(crc_bit),
    .rem(crc16_rem)
  );

  usb_rx_pack #(.CW(CW)) u_pack (
    .clk(clk), .rst(rst), .bit_vld(bit_vld), .bit_val(bit_val), .sop(sop),
    .eop(eop), .eop_bad(eop_bad), .stuff_err(stuff_err),
    .crc5_rem(crc5_rem), .crc16_rem(crc16_rem),
    .crc_init(crc_init), .crc_en(crc_en), .crc_bit(crc_bit),
    .byte_data(rx_byte), .byte_vld(rx_byte_vld), .pkt_start(rx_pkt_start),
    .pkt_end(rx_pkt_end), .pid_code(rx_pid), .pid_ok(rx_pid_ok),
    .crc_ok(rx_crc_ok), .frame_err(rx_frame_err)
  );

endmodule

// File: tb/usb_fs_rx_test.sv
module usb_fs_rx_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_en = 1'b0;
  logic rx_dp = 1'b1;
  logic rx_se0 = 1'b0;
  logic [7:0] rx_byte;
  logic rx_byte_vld, rx_pkt_start, rx_pkt_end;
  logic [3:0] rx_pid;
  logic rx_pid_ok, rx_crc_ok, rx_frame_err;

  usb_fs_rx uut (
    .clk(clk), .rst(rst), .bit_en(bit_en), .rx_dp(rx_dp), .rx_se0(rx_se0),
    .rx_byte(rx_byte), .rx_byte_vld(rx_byte_vld), .rx_pkt_start(rx_pkt_start),
    .rx_pkt_end(rx_pkt_end), .rx_pid(rx_pid), .rx_pid_ok(rx_pid_ok),
    .rx_crc_ok(rx_crc_ok), .rx_frame_err(rx_frame_err)
  );

  always #5 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;

  // mode: 0 token, 1 data, 2 pid only, 3 data with a flipped bit, 4 token with a flipped bit
  // fields: mode, payload count, pid, d0, d1, d2, expected {pid_ok, crc_ok, frame_err}
  localparam int NV = 17;
  localparam logic [47:0] VEC [NV] = '{
    {4'd0, 4'd0, 8'hE1, 8'h85, 8'h00, 8'h00, 8'b110},
    {4'd0, 4'd0, 8'h69, 8'hFF, 8'h07, 8'h00, 8'b110},
    {4'd0, 4'd0, 8'hA5, 8'hA3, 8'h04, 8'h00, 8'b110},
    {4'd0, 4'd0, 8'h2D, 8'h00, 8'h00, 8'h00, 8'b110},
    {4'd1, 4'd3, 8'hC3, 8'h01, 8'hFF, 8'h80, 8'b110},
    {4'd1, 4'd0, 8'h4B, 8'h00, 8'h00, 8'h00, 8'b110},
    {4'd2, 4'd0, 8'hD2, 8'h00, 8'h00, 8'h00, 8'b110},
    {4'd2, 4'd0, 8'h5A, 8'h00, 8'h00, 8'h00, 8'b110},
    {4'd2, 4'd0, 8'h1E, 8'h00, 8'h00, 8'h00, 8'b110},
    {4'd2, 4'd0, 8'h3C, 8'h00, 8'h00, 8'h00, 8'b110},
    {4'd2, 4'd0, 8'h12, 8'h00, 8'h00, 8'h00, 8'b000},
    {4'd2, 4'd0, 8'h87, 8'h00, 8'h00, 8'h00, 8'b000},
    {4'd3, 4'd2, 8'hC3, 8'hAA, 8'h55, 8'h00, 8'b100},
    {4'd4, 4'd0, 8'h69, 8'h12, 8'h03, 8'h00, 8'b100},
    {4'd1, 4'd3, 8'h4B, 8'hFF, 8'hFF, 8'hFF, 8'b110},
    {4'd1, 4'd1, 8'hE1, 8'h33, 8'h00, 8'h00, 8'b100},
    {4'd1, 4'd0, 8'hD2, 8'h00, 8'h00, 8'h00, 8'b100}
  };

  logic tx_bits [0:255];
  int   tx_n;
  logic lvl;
  int   ones;
  int   gap = 0;

  logic [7:0] mon_bytes [0:31];
  int   mon_n, mon_starts, mon_ends;
  logic m_pid_ok, m_crc_ok, m_ferr;

  always @(negedge clk) begin
    if (!rst) begin
      if (rx_byte_vld) begin
        if (mon_n < 32) mon_bytes[mon_n] = rx_byte;
        mon_n++;
      end
      if (rx_pkt_start) mon_starts++;
      if (rx_pkt_end) begin
        mon_ends++;
        m_pid_ok = rx_pid_ok;
        m_crc_ok = rx_crc_ok;
        m_ferr   = rx_frame_err;
      end
    end
  end

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic clear_mon();
    mon_n = 0; mon_starts = 0; mon_ends = 0;
    m_pid_ok = 1'b0; m_crc_ok = 1'b0; m_ferr = 1'b0;
  endtask

  task automatic send_line(input logic dp, input logic se0);
    @(negedge clk);
    bit_en = 1'b1; rx_dp = dp; rx_se0 = se0;
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      bit_en = 1'b0; rx_dp = ~rx_dp; rx_se0 = g[0];
    end
  endtask

  task automatic send_sync();
    for (int i = 0; i < 7; i++) send_line(i[0], 1'b0);
    send_line(1'b0, 1'b0);
    lvl = 1'b0; ones = 0;
  endtask

  // NRZI with stuffing; brk skips the transition at the first stuffed position
  task automatic send_stream(input int nbits, input bit brk);
    bit broke = 1'b0;
    for (int i = 0; i < nbits; i++) begin
      if (tx_bits[i] == 1'b0) begin
        lvl = ~lvl; ones = 0;
      end else begin
        ones++;
      end
      send_line(lvl, 1'b0);
      if (ones == 6) begin
        if (brk && !broke) broke = 1'b1;
        else lvl = ~lvl;
        send_line(lvl, 1'b0);
        ones = 0;
      end
    end
  endtask

  task automatic send_eop();
    send_line(1'b1, 1'b1);
    send_line(1'b1, 1'b1);
    send_line(1'b1, 1'b0);
    for (int i = 0; i < 4; i++) send_line(1'b1, 1'b0);
  endtask

  task automatic add_bits(input logic [15:0] v, input int n);
    for (int i = 0; i < n; i++) begin
      tx_bits[tx_n] = v[i];
      tx_n++;
    end
  endtask

  task automatic add_crc5();
    logic [4:0] c = 5'h1F;
    logic q;
    int last = tx_n;
    for (int i = 8; i < last; i++) begin
      q = c[4] ^ tx_bits[i];
      c = {c[3:0], 1'b0};
      if (q) c = c ^ 5'b00101;
    end
    for (int k = 4; k >= 0; k--) begin
      tx_bits[tx_n] = ~c[k];
      tx_n++;
    end
  endtask

  task automatic add_crc16();
    logic [15:0] c = 16'hFFFF;
    logic q;
    int last = tx_n;
    for (int i = 8; i < last; i++) begin
      q = c[15] ^ tx_bits[i];
      c = {c[14:0], 1'b0};
      if (q) c = c ^ 16'h8005;
    end
    for (int k = 15; k >= 0; k--) begin
      tx_bits[tx_n] = ~c[k];
      tx_n++;
    end
  endtask

  task automatic build_vec(input logic [47:0] v);
    logic [3:0] mode = v[47:44];
    int nb = int'(v[43:40]);
    logic [7:0] d [3];
    d[0] = v[31:24]; d[1] = v[23:16]; d[2] = v[15:8];
    tx_n = 0;
    add_bits({8'h00, v[39:32]}, 8);
    if (mode == 4'd0 || mode == 4'd4) begin
      add_bits({5'h0, d[1][2:0], d[0]}, 11);
      add_crc5();
    end else if (mode == 4'd1 || mode == 4'd3) begin
      for (int i = 0; i < nb; i++) add_bits({8'h00, d[i]}, 8);
      add_crc16();
    end
    if (mode == 4'd3 || mode == 4'd4) tx_bits[12] = ~tx_bits[12];
  endtask

  // exp values of -1 skip that check
  task automatic check_pkt(input string tag, input int ex_start, input int ex_end,
                           input int ex_pid_ok, input int ex_crc_ok, input int ex_ferr);
    int nexp = tx_n / 8;
    int mism = 0;
    logic [7:0] eb;
    check(mon_starts == ex_start, {tag, " R5/R1 start count"}, mon_starts, ex_start);
    check(mon_ends == ex_end, {tag, " R10 end count"}, mon_ends, ex_end);
    check(mon_n == nexp, {tag, " R5 byte count"}, mon_n, nexp);
    for (int k = 0; k < nexp && k < mon_n && k < 32; k++) begin
      for (int b = 0; b < 8; b++) eb[b] = tx_bits[8 * k + b];
      if (mon_bytes[k] !== eb) mism++;
    end
    check(mism == 0, {tag, " R2 R3 R5 byte contents"}, mism, 0);
    if (ex_start == 1) begin
      for (int b = 0; b < 4; b++) eb[b] = tx_bits[b];
      check(rx_pid == eb[3:0], {tag, " R6 pid code"}, rx_pid, eb[3:0]);
    end
    if (ex_pid_ok >= 0) check(m_pid_ok == ex_pid_ok[0], {tag, " R6 pid_ok"}, m_pid_ok, ex_pid_ok);
    if (ex_crc_ok >= 0) check(m_crc_ok == ex_crc_ok[0], {tag, " R7 R8 R9 crc_ok"}, m_crc_ok, ex_crc_ok);
    if (ex_ferr >= 0) check(m_ferr == ex_ferr[0], {tag, " R4 R10 R11 frame_err"}, m_ferr, ex_ferr);
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R13 reset state
    check({rx_byte_vld, rx_pkt_start, rx_pkt_end, rx_pid_ok, rx_crc_ok, rx_frame_err} == 6'b0,
          "R13 strobes and flags after reset", 1, 0);
    check(rx_byte == 8'h00 && rx_pid == 4'h0, "R13 byte and pid after reset",
          {rx_byte, rx_pid}, 0);
    for (int i = 0; i < 3; i++) send_line(1'b1, 1'b0);

    // table walk: R6 R7 R8 R9
    for (int v = 0; v < NV; v++) begin
      clear_mon();
      build_vec(VEC[v]);
      send_sync();
      send_stream(tx_n, 1'b0);
      send_eop();
      check_pkt($sformatf("vec%0d", v), 1, 1, int'(VEC[v][2]), int'(VEC[v][1]), int'(VEC[v][0]));
    end

    // R4 stuffing error: no transition at the first stuffed position
    clear_mon();
    build_vec({4'd1, 4'd2, 8'hC3, 8'hFF, 8'hFF, 8'h00, 8'b0});
    send_sync();
    send_stream(tx_n, 1'b1);
    send_eop();
    check_pkt("R4 stuff", 1, 1, 1, -1, 1);

    // R11 partial byte at end
    clear_mon();
    tx_n = 0;
    add_bits(16'h00D2, 8);
    add_bits(16'h0005, 3);
    send_sync();
    send_stream(tx_n, 1'b0);
    send_eop();
    check_pkt("R11 partial", 1, 1, 1, -1, 1);

    // R11 no identifier at all
    clear_mon();
    tx_n = 0;
    send_sync();
    send_eop();
    check_pkt("R11 empty", 0, 1, 0, 0, 1);

    // R1 broken synchronisation pattern never starts a packet
    clear_mon();
    tx_n = 0;
    for (int i = 0; i < 8; i++) send_line(i[0], 1'b0);
    for (int i = 0; i < 3; i++) send_line(1'b1, 1'b0);
    send_line(1'b0, 1'b0);
    send_line(1'b0, 1'b0);
    send_line(1'b1, 1'b0);
    send_eop();
    check_pkt("R1 broken sync", 0, 0, -1, -1, -1);

    // R10 bad end shape: one SE0 then K
    clear_mon();
    build_vec(VEC[0]);
    send_sync();
    send_stream(tx_n, 1'b0);
    send_line(1'b1, 1'b1);
    send_line(1'b0, 1'b0);
    for (int i = 0; i < 4; i++) send_line(1'b1, 1'b0);
    check_pkt("R10 bad end", 1, 1, 1, -1, 1);

    // R12 gaps with junk line values between strobes
    gap = 2;
    clear_mon();
    build_vec(VEC[4]);
    send_sync();
    send_stream(tx_n, 1'b0);
    send_eop();
    check_pkt("R12 gaps", 1, 1, 1, 1, 0);
    gap = 0;

    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule